// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the programming state of one 32-bit bus-master DMA channel that sits beside a SCSI protocol core. Software loads a starting byte count, a starting memory address and a starting descriptor address, then writes a command word. A start command copies the starting values into working copies and enables the channel. While enabled, the core asks for each data move through a simple request port and gets back a grant that has been clamped to what is left in the count. The working count and address then advance by the granted length.

Status collects the abort, error, done and count-exhausted events. It can be cleared in one of two ways, picked by a mode input: software writes ones to the bits it wants cleared, or the bits clear themselves when status is read. The core's interrupt line is not stored in status. It is merged into the status word at the moment of the read.

Top module: `bmdma_channel`

## Requirements
- R1: After reset the command word, the working count and the status read as 0, the working address reads 0xFFFFFFFF, the working descriptor reads 0xFFFFFFFD, and `dma_en` is low.
- R2: Writing the command word (index 0) with bits[1:0]=3 (start) copies start count (index 1) to working count (index 3), start address (index 2) to working address (index 4), and start descriptor (index 6) to working descriptor (index 7). The same write clears status bits[5:0] and raises `dma_en`.
- R3: The command write decodes bits[1:0]. Value 0 (idle) lowers `dma_en`. Value 2 (abort) raises `abort_pulse` for exactly one cycle and sets status bit 2. Value 1 (blast) changes nothing except the stored command word.
- R4: Command bit 7 sets the allowed direction: 1 means device-to-memory and 0 means memory-to-device. While enabled, a request whose `xfer_dir` differs is answered with `xfer_reject`, sets status bit 1 (error), and leaves the counters unchanged.
- R5: An accepted request is granted min(`xfer_len`, working count). One cycle after the request, `xfer_ack` is high and `xfer_addr` carries the working address held before the move. The working count then drops by the grant and the working address rises by the grant, modulo 2^32.
- R6: A request made while `dma_en` is low is rejected and moves no counter.
- R7: With `stat_clr_on_rd` low, writing status (index 5) clears error (bit 1), abort (bit 2) and done (bit 3) wherever the written bit is 1. Reads leave status unchanged.
- R8: With `stat_clr_on_rd` high, a status read returns the bits and then clears error, abort and done. Status writes have no effect in this mode.
- R9: A status read returns bit 4 set whenever `core_irq` is high in the read cycle. Otherwise bit 4 reads 0.
- R10: A `cmd_done` pulse forces the working count to 0 and sets status bit 3 (done).
- R11: Status bit 5 is set when an accepted request leaves the working count at zero.
- R12: `reg_rdata` is valid the cycle after `reg_rd`. Writes to the working registers (indices 3, 4, 7) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| stat_clr_on_rd | input | 1 | 1: status clears on read; 0: write-one-to-clear |
| core_irq | input | 1 | Live interrupt from the SCSI core |
| cmd_done | input | 1 | Command completion pulse from the core |
| xfer_req | input | 1 | Data move request from the core |
| xfer_dir | input | 1 | Requested direction, 1 = device-to-memory |
| xfer_len | input | LEN_W | Requested length in bytes |
| xfer_ack | output | 1 | Request granted |
| xfer_reject | output | 1 | Request refused |
| xfer_gnt_len | output | LEN_W | Granted length |
| xfer_addr | output | DATA_W | Memory address for the granted move |
| dma_en | output | 1 | Channel enabled |
| abort_pulse | output | 1 | One-cycle cancel request to the core |

## Verification
The hardest state to reach from the ports is a status word that holds several sticky bits at once, so that clearing one bit can be shown to leave the others alone. The stimulus builds this state on purpose. It sets error through a direction mismatch, sets abort through an abort command, and sets done through a completion pulse. It then clears one bit at a time in write-one-to-clear mode. After that it switches the mode input and shows that a write is ignored while a read clears. The clamp edges are driven from a vector table: a count smaller than the request, a count that is already zero, and an address that wraps past the top of memory.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int IDX_W = 3;

  localparam logic [IDX_W-1:0] IX_CMD   = 3'd0;
  localparam logic [IDX_W-1:0] IX_SCNT  = 3'd1;
  localparam logic [IDX_W-1:0] IX_SADR  = 3'd2;
  localparam logic [IDX_W-1:0] IX_WCNT  = 3'd3;
  localparam logic [IDX_W-1:0] IX_WADR  = 3'd4;
  localparam logic [IDX_W-1:0] IX_STAT  = 3'd5;
  localparam logic [IDX_W-1:0] IX_SDESC = 3'd6;
  localparam logic [IDX_W-1:0] IX_WDESC = 3'd7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int STAT_W  = 6;
  localparam int SB_PWDN = 0;
  localparam int SB_ERR  = 1;
  localparam int SB_ABT  = 2;
  localparam int SB_DONE = 3;
  localparam int SB_IRQ  = 4;
  localparam int SB_BCZ  = 5;
  localparam int CMD_DIR_BIT = 7;
endpackage

// File: rtl/bmdma_cmd_ctrl.sv
module bmdma_cmd_ctrl
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic              dma_en,
  output logic              start_now,
  output logic              abort_now,
  output logic              abort_q
);
  dma_op_e op;
  assign op        = dma_op_e'(wdata[1:0]);
  assign start_now = wr_cmd && (op == OP_START);
  assign abort_now = wr_cmd && (op == OP_ABORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      dma_en  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= abort_now;
      if (wr_cmd) begin
        cmd_q <= wdata;
        case (op)
          OP_IDLE:  dma_en <= 1'b0;
          OP_START: dma_en <= 1'b1;
          default:  dma_en <= dma_en;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_xfer.sv
module bmdma_xfer #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] scnt,
  input  logic [DATA_W-1:0] sadr,
  input  logic [DATA_W-1:0] sdesc,
  input  logic              done_in,
  input  logic              en,
  input  logic              cmd_dir,
  input  logic              req,
  input  logic              req_dir,
  input  logic [LEN_W-1:0]  req_len,
  output logic [DATA_W-1:0] wcnt_q,
  output logic [DATA_W-1:0] wadr_q,
  output logic [DATA_W-1:0] wdesc_q,
  output logic              ack_q,
  output logic              rej_q,
  output logic [LEN_W-1:0]  gnt_len_q,
  output logic [DATA_W-1:0] gnt_adr_q,
  output logic              dir_err,
  output logic              hit_zero
);
  localparam logic [DATA_W-1:0] WADR_RST  = '1;
  localparam logic [DATA_W-1:0] WDESC_RST = {{(DATA_W-2){1'b1}}, 2'b01};

  logic              accept;
  logic [DATA_W-1:0] len_ext;
  logic [DATA_W-1:0] mv;

  assign accept   = req && en && (req_dir == cmd_dir);
  assign dir_err  = req && en && (req_dir != cmd_dir);
  assign len_ext  = {{(DATA_W-LEN_W){1'b0}}, req_len};
  assign mv       = (len_ext < wcnt_q) ? len_ext : wcnt_q;
  assign hit_zero = accept && (mv == wcnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q    <= '0;
      wadr_q    <= WADR_RST;
      wdesc_q   <= WDESC_RST;
      ack_q     <= 1'b0;
      rej_q     <= 1'b0;
      gnt_len_q <= '0;
      gnt_adr_q <= '0;
    end else begin
      ack_q <= accept;
      rej_q <= req && !accept;
      if (accept) begin
        gnt_len_q <= mv[LEN_W-1:0];
        gnt_adr_q <= wadr_q;
      end
      if (start) begin
        wcnt_q  <= scnt;
        wadr_q  <= sadr;
        wdesc_q <= sdesc;
      end else if (done_in) begin
        wcnt_q <= '0;
      end else if (accept) begin
        wcnt_q <= wcnt_q - mv;
        wadr_q <= wadr_q + mv;
      end
    end
  end
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              set_err,
  input  logic              set_abt,
  input  logic              set_done,
  input  logic              set_bcz,
  input  logic              wr_stat,
  input  logic [STAT_W-1:0] wbits,
  input  logic              rd_stat,
  input  logic              clr_on_rd,
  input  logic              core_irq,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] stat_view
);
  localparam logic [STAT_W-1:0] STICKY =
    STAT_W'((1 << SB_ERR) | (1 << SB_ABT) | (1 << SB_DONE));

  logic [STAT_W-1:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (start) begin
      nxt = '0;
    end else begin
      if (wr_stat && !clr_on_rd) nxt = nxt & ~(wbits & STICKY);
      if (rd_stat && clr_on_rd)  nxt = nxt & ~STICKY;
    end
    if (set_err)  nxt[SB_ERR]  = 1'b1;
    if (set_abt)  nxt[SB_ABT]  = 1'b1;
    if (set_done) nxt[SB_DONE] = 1'b1;
    if (set_bcz)  nxt[SB_BCZ]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end

  always_comb begin
    stat_view = stat_q;
    stat_view[SB_IRQ] = stat_q[SB_IRQ] | core_irq;
  end
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              stat_clr_on_rd,
  input  logic              core_irq,
  input  logic              cmd_done,
  input  logic              xfer_req,
  input  logic              xfer_dir,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              xfer_ack,
  output logic              xfer_reject,
  output logic [LEN_W-1:0]  xfer_gnt_len,
  output logic [DATA_W-1:0] xfer_addr,
  output logic              dma_en,
  output logic              abort_pulse
);
  logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, sdesc_q;
  logic [DATA_W-1:0] wcnt_q, wadr_q, wdesc_q;
  logic [STAT_W-1:0] stat_q, stat_view;
  logic start_now, abort_now, dir_err, hit_zero;
  logic wr_cmd, wr_stat, rd_stat;

  assign wr_cmd  = reg_wr && (reg_idx == IX_CMD);
  assign wr_stat = reg_wr && (reg_idx == IX_STAT);
  assign rd_stat = reg_rd && (reg_idx == IX_STAT);

  bmdma_cmd_ctrl #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wdata(reg_wdata),
    .cmd_q(cmd_q), .dma_en(dma_en), .start_now(start_now),
    .abort_now(abort_now), .abort_q(abort_pulse)
  );

  bmdma_xfer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_xfer (
    .clk(clk), .rst(rst), .start(start_now),
    .scnt(scnt_q), .sadr(sadr_q), .sdesc(sdesc_q),
    .done_in(cmd_done), .en(dma_en), .cmd_dir(cmd_q[CMD_DIR_BIT]),
    .req(xfer_req), .req_dir(xfer_dir), .req_len(xfer_len),
    .wcnt_q(wcnt_q), .wadr_q(wadr_q), .wdesc_q(wdesc_q),
    .ack_q(xfer_ack), .rej_q(xfer_reject), .gnt_len_q(xfer_gnt_len),
    .gnt_adr_q(xfer_addr), .dir_err(dir_err), .hit_zero(hit_zero)
  );

  bmdma_status u_stat (
    .clk(clk), .rst(rst), .start(start_now),
    .set_err(dir_err), .set_abt(abort_now), .set_done(cmd_done),
    .set_bcz(hit_zero), .wr_stat(wr_stat), .wbits(reg_wdata[STAT_W-1:0]),
    .rd_stat(rd_stat), .clr_on_rd(stat_clr_on_rd), .core_irq(core_irq),
    .stat_q(stat_q), .stat_view(stat_view)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt_q  <= '0;
      sadr_q  <= '0;
      sdesc_q <= '0;
    end else if (reg_wr) begin
      case (reg_idx)
        IX_SCNT:  scnt_q  <= reg_wdata;
        IX_SADR:  sadr_q  <= reg_wdata;
        IX_SDESC: sdesc_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_idx)
        IX_CMD:   reg_rdata <= cmd_q;
        IX_SCNT:  reg_rdata <= scnt_q;
        IX_SADR:  reg_rdata <= sadr_q;
        IX_WCNT:  reg_rdata <= wcnt_q;
        IX_WADR:  reg_rdata <= wadr_q;
        IX_STAT:  reg_rdata <= {{(DATA_W-STAT_W){1'b0}}, stat_view};
        IX_SDESC: reg_rdata <= sdesc_q;
        default:  reg_rdata <= wdesc_q;
      endcase
    end
  end
endmodule

// File: rtl/bmdma_channel_chk.sv
module bmdma_channel_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              core_irq,
  input logic              cmd_done,
  input logic              xfer_req,
  input logic              xfer_dir,
  input logic [LEN_W-1:0]  xfer_len,
  input logic              xfer_ack,
  input logic              xfer_reject,
  input logic [LEN_W-1:0]  xfer_gnt_len,
  input logic              dma_en,
  input logic              cmd_dir,
  input logic [DATA_W-1:0] scnt_q,
  input logic [DATA_W-1:0] wcnt_q,
  input logic              done_bit
);
  logic start_wr;
  assign start_wr = reg_wr && (reg_idx == 3'd0) && (reg_wdata[1:0] == 2'd3);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> (dma_en && wcnt_q == $past(scnt_q)));

  assert_dir_reject_R4: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && dma_en && (xfer_dir != cmd_dir)) |=> (xfer_reject && !xfer_ack));

  assert_grant_clamp_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> (xfer_gnt_len <= $past(xfer_len)));

  assert_ack_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(xfer_ack && xfer_reject));

  assert_disabled_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !dma_en) |=> (xfer_reject && !xfer_ack));

  assert_irq_merge_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_idx == 3'd5 && core_irq) |=> reg_rdata[4]);

  assert_done_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !start_wr) |=> (wcnt_q == '0 && done_bit));
endmodule

bind bmdma_channel bmdma_channel_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq),
  .cmd_done(cmd_done), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
  .xfer_len(xfer_len), .xfer_ack(xfer_ack), .xfer_reject(xfer_reject),
  .xfer_gnt_len(xfer_gnt_len), .dma_en(dma_en), .cmd_dir(cmd_q[7]),
  .scnt_q(scnt_q), .wcnt_q(wcnt_q), .done_bit(stat_q[3])
);

// File: tb/sim_bmdma_channel.sv
module sim_bmdma_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_idx = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        stat_clr_on_rd = 0, core_irq = 0, cmd_done = 0;
  logic        xfer_req = 0, xfer_dir = 0;
  logic [15:0] xfer_len = 0;
  logic        xfer_ack, xfer_reject, dma_en, abort_pulse;
  logic [15:0] xfer_gnt_len;
  logic [31:0] xfer_addr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bmdma_channel u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_clr_on_rd(stat_clr_on_rd),
    .core_irq(core_irq), .cmd_done(cmd_done), .xfer_req(xfer_req),
    .xfer_dir(xfer_dir), .xfer_len(xfer_len), .xfer_ack(xfer_ack),
    .xfer_reject(xfer_reject), .xfer_gnt_len(xfer_gnt_len), .xfer_addr(xfer_addr),
    .dma_en(dma_en), .abort_pulse(abort_pulse)
  );

  typedef struct packed {
    logic [31:0] cnt;
    logic [31:0] adr;
    logic        dir;
    logic [15:0] len;
    logic [15:0] glen;
    logic [31:0] wcnt;
    logic        bcz;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'd100,        32'h0000_1000, 1'b1, 16'd40,     16'd40,     32'd60, 1'b0},
    '{32'd16,         32'h2000_0000, 1'b0, 16'd64,     16'd16,     32'd0,  1'b1},
    '{32'h0001_0000,  32'hFFFF_FFF0, 1'b1, 16'hFFFF,   16'hFFFF,   32'd1,  1'b0},
    '{32'd5,          32'h0000_0040, 1'b0, 16'd5,      16'd5,      32'd0,  1'b1},
    '{32'd0,          32'h0000_0080, 1'b1, 16'd8,      16'd0,      32'd0,  1'b1}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_idx = idx;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic xf(input logic dir, input logic [15:0] len);
    @(negedge clk);
    xfer_req = 1; xfer_dir = dir; xfer_len = len;
    @(negedge clk);
    xfer_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset values
    chk("R1 dma_en", {31'b0, dma_en}, 32'd0);
    rd(3'd0, d); chk("R1 cmd", d, 32'd0);
    rd(3'd3, d); chk("R1 wcnt", d, 32'd0);
    rd(3'd4, d); chk("R1 waddr", d, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R1 wdesc", d, 32'hFFFF_FFFD);
    rd(3'd5, d); chk("R1 status", d, 32'd0);

    // Vector table: R5 clamp/update, R11 count-zero bit, R2 load
    foreach (VECS[i]) begin
      wr(3'd1, VECS[i].cnt);
      wr(3'd2, VECS[i].adr);
      wr(3'd0, {24'b0, VECS[i].dir, 5'b0, 2'b11});
      chk("R2 dma_en", {31'b0, dma_en}, 32'd1);
      xf(VECS[i].dir, VECS[i].len);
      chk("R5 ack", {31'b0, xfer_ack}, 32'd1);
      chk("R5 gnt_len", {16'b0, xfer_gnt_len}, {16'b0, VECS[i].glen});
      chk("R5 gnt_addr", xfer_addr, VECS[i].adr);
      rd(3'd3, d); chk("R5 wcnt", d, VECS[i].wcnt);
      rd(3'd4, d); chk("R5 waddr", d, VECS[i].adr + {16'b0, VECS[i].glen});
      rd(3'd5, d); chk("R11 status", d, VECS[i].bcz ? 32'h20 : 32'h0);
    end

    // R2 descriptor copy and status clear
    wr(3'd6, 32'hABCD_0000);
    wr(3'd0, 32'h0000_0083);
    rd(3'd7, d); chk("R2 wdesc", d, 32'hABCD_0000);
    rd(3'd5, d); chk("R2 status cleared", d, 32'd0);
    rd(3'd3, d); chk("R2 wcnt", d, 32'd0);

    // R12 working registers ignore writes
    wr(3'd3, 32'h1234_5678);
    wr(3'd7, 32'h1111_1111);
    rd(3'd3, d); chk("R12 wcnt write ignored", d, 32'd0);
    rd(3'd7, d); chk("R12 wdesc write ignored", d, 32'hABCD_0000);

    // R4 direction mismatch
    wr(3'd1, 32'd50); wr(3'd2, 32'h300);
    wr(3'd0, 32'h0000_0083);
    xf(1'b0, 16'd10);
    chk("R4 reject", {31'b0, xfer_reject}, 32'd1);
    chk("R4 no ack", {31'b0, xfer_ack}, 32'd0);
    rd(3'd3, d); chk("R4 wcnt kept", d, 32'd50);
    rd(3'd5, d); chk("R4 error bit", d, 32'h02);

    // R3 abort
    wr(3'd0, 32'h0000_0082);
    chk("R3 abort pulse", {31'b0, abort_pulse}, 32'd1);
    @(negedge clk);
    chk("R3 abort one cycle", {31'b0, abort_pulse}, 32'd0);
    rd(3'd5, d); chk("R3 abort bit", d, 32'h06);

    // R3 blast
    wr(3'd0, 32'h0000_0081);
    chk("R3 blast keeps en", {31'b0, dma_en}, 32'd1);
    chk("R3 blast no abort", {31'b0, abort_pulse}, 32'd0);
    rd(3'd0, d); chk("R3 blast cmd stored", d, 32'h81);

    // R10 completion
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
    rd(3'd3, d); chk("R10 wcnt zero", d, 32'd0);
    rd(3'd5, d); chk("R10 done bit", d, 32'h0E);

    // R7 write-one-to-clear, one bit at a time
    wr(3'd5, 32'h04);
    rd(3'd5, d); chk("R7 clear abort only", d, 32'h0A);
    wr(3'd5, 32'h02);
    rd(3'd5, d); chk("R7 clear error only", d, 32'h08);
    rd(3'd5, d); chk("R7 read keeps", d, 32'h08);

    // R9 live irq merge
    core_irq = 1;
    rd(3'd5, d); chk("R9 irq set", d, 32'h18);
    core_irq = 0;
    rd(3'd5, d); chk("R9 irq clear", d, 32'h08);

    // R8 clear on read
    stat_clr_on_rd = 1;
    wr(3'd5, 32'h08);
    rd(3'd5, d); chk("R8 write ignored", d, 32'h08);
    rd(3'd5, d); chk("R8 cleared by read", d, 32'h00);
    stat_clr_on_rd = 0;

    // R3 idle and R6 disabled
    wr(3'd1, 32'd20);
    wr(3'd0, 32'h0000_0003);
    wr(3'd0, 32'h0000_0000);
    chk("R3 idle disables", {31'b0, dma_en}, 32'd0);
    xf(1'b0, 16'd4);
    chk("R6 reject", {31'b0, xfer_reject}, 32'd1);
    rd(3'd3, d); chk("R6 wcnt kept", d, 32'd20);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule